// File: doc/BRIEF.md
# Serial Receive Deserializer with Start-Pattern Search

This block turns a recovered serial bit stream into parallel words. Each bit arrives with a one-cycle strobe. The stream can optionally be inverted. The block then searches the stream for a programmable 8-bit start pattern. Once the pattern is found, the block stops searching and shifts the following bits into a word register, least significant bit first. When a programmed number of bits (1 to 16) has been gathered, the word is moved into a receive buffer and a buffer-full flag is raised.

An end-of-packet pulse on a dedicated input closes the frame early. The pulse moves any partial word into the buffer, right-justified. It also stores the number of bits that word actually holds and sets an end-of-packet flag. Pattern searching starts again after the pulse. A bypass bit skips the search entirely, so that plain synchronous serial links can be received. Software reaches the configuration, buffer, bit count and flags through a small register port, and a level interrupt reports buffer-full and end-of-packet events when enabled.

The serial input is a stream that cannot be held back: there is no ready signal toward the line. Back-pressure is therefore replaced by a deadline. Software must read the buffer before the next word completes, which is within one word time. If it does not, the older word is lost and an overrun flag is set.

Top module: `sr_deser_rx`

## Requirements
- R1: After reset the control register reads 0, the pattern register reads 0, the length register reads 7 (eight-bit words), the buffer and bit-count registers read 0, the flags read 0x8 (searching only) and `irq_o` is low.
- R2: With control bit 0 set, every strobed bit is inverted before both the pattern comparison and the shifting; with it clear, bits pass unchanged.
- R3: While searching, a match occurs on a strobed bit when the last eight bits accepted since reset or the last end-of-packet equal the pattern register, with pattern bit 0 being the oldest of the eight; fewer than eight accepted bits never match. After a match, the search stops and the next strobed bit becomes word bit 0.
- R4: While a frame is being received, payload bits equal to the pattern are stored as data and do not restart the word.
- R5: The length register field [3:0] holds the word length minus one. The field is sampled with the first bit of each word, so a write in the middle of a word takes effect from the next word. When the word is complete, the buffer (register 3) holds it with the first received bit in bit 0, and flag bit 0 (full) is set.
- R6: On an end-of-packet pulse, register 4 takes the number of bits in the unfinished word. If that count is non-zero, the partial word moves right-justified into the buffer and sets full. Flag bit 1 (end-of-packet) is set, and the search re-arms. A bit strobe in the same cycle as the pulse is discarded.
- R7: The full flag clears when register 3 is read, or when a one is written to flag bit 0 of register 5. A capture in the same cycle wins over the clear.
- R8: A capture while full is set and not being cleared in that cycle sets flag bit 2 (overrun); the buffer takes the newer word. Writing one to flag bit 2 clears the overrun flag.
- R9: `irq_o` is high exactly when (full and control bit 1) or (end-of-packet flag and control bit 2) holds.
- R10: With control bit 3 set (bypass), bits shift into words without any pattern match, and flag bit 3 (searching) reads 0.
- R11: Registers 0 (control, 4 bits), 1 (pattern, 8 bits) and 2 (length, 4 bits) read back what was written; register 5 bit 3 reads 1 while a pattern search is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_i | input | 1 | Serial data bit |
| bit_stb_i | input | 1 | One-cycle strobe marking a valid bit on `bit_i` |
| eop_i | input | 1 | End-of-packet pulse |
| reg_addr_i | input | 3 | Register address |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 16 | Register write data |
| reg_rd_i | input | 1 | Register read strobe (a read of address 3 clears full) |
| reg_rdata_o | output | 16 | Read data for `reg_addr_i`, combinational |
| irq_o | output | 1 | Level interrupt request |

## Verification
The assertions take for granted that register accesses hold valid addresses and that the strobe, end-of-packet and read inputs are known after reset. The read-clear property assumes that no capture lands in the cycle of the read, because a capture legally overrides the clear. The stimulus keeps within this by leaving an idle cycle after each bit strobe and by performing every buffer read between bits. The one place where a strobe and an end-of-packet pulse coincide is a deliberate directed case.

// File: rtl/sr_rx_pkg.sv
package sr_rx_pkg;
  typedef enum logic [2:0] {
    RA_CTRL  = 3'd0,
    RA_SYNC  = 3'd1,
    RA_LEN   = 3'd2,
    RA_BUF   = 3'd3,
    RA_RCNT  = 3'd4,
    RA_FLAGS = 3'd5
  } rx_reg_e;

  localparam int FL_FULL = 0;
  localparam int FL_EOP  = 1;
  localparam int FL_OVR  = 2;
  localparam int FL_HUNT = 3;

  // bit 0 invert, bit 1 full irq enable, bit 2 eop irq enable, bit 3 bypass
  typedef struct packed {
    logic bypass;
    logic ie_eop;
    logic ie_full;
    logic invert;
  } rx_ctrl_t;
endpackage

// File: rtl/sr_rx_sync.sv
module sr_rx_sync #(
  parameter int PAT_W = 8,
  localparam int FILL_W = $clog2(PAT_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_stb_i,
  input  logic             bit_val_i,
  input  logic             arm_i,
  input  logic             enable_i,
  input  logic [PAT_W-1:0] pattern_i,
  output logic             match_o
);
  logic [PAT_W-1:0]  hist_q, hist_nx;
  logic [FILL_W-1:0] fill_q;
  logic              primed;

  // newest bit enters at the top, so bit 0 holds the oldest of the window
  assign hist_nx = {bit_val_i, hist_q[PAT_W-1:1]};
  assign primed  = (fill_q == FILL_W'(PAT_W - 1));
  assign match_o = enable_i && bit_stb_i && !arm_i && primed && (hist_nx == pattern_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= '0;
      fill_q <= '0;
    end else if (arm_i) begin
      hist_q <= '0;
      fill_q <= '0;
    end else if (enable_i && bit_stb_i) begin
      hist_q <= hist_nx;
      if (!primed) fill_q <= fill_q + 1'b1;
    end
  end
endmodule

// File: rtl/sr_rx_shift.sv
module sr_rx_shift #(
  parameter int BUF_W    = 16,
  parameter int DEF_BITS = 8,
  localparam int IDX_W = $clog2(BUF_W),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_stb_i,
  input  logic             bit_val_i,
  input  logic             eop_i,
  input  logic             run_i,
  input  logic [IDX_W-1:0] len_m1_i,
  output logic             cap_valid_o,
  output logic [BUF_W-1:0] cap_data_o,
  output logic [CNT_W-1:0] eop_bits_o,
  output logic [IDX_W-1:0] bit_cnt_o,
  output logic [IDX_W-1:0] len_m1_o
);
  logic [IDX_W-1:0] cnt_q, len_q, len_eff;
  logic [BUF_W-1:0] sh_q, merged;
  logic             take, done;

  // word length is frozen from the first bit of each word
  assign len_eff = (cnt_q == '0) ? len_m1_i : len_q;
  assign take    = bit_stb_i && run_i && !eop_i;
  assign done    = take && (cnt_q == len_eff);
  assign merged  = sh_q | ({{(BUF_W-1){1'b0}}, bit_val_i} << cnt_q);

  assign cap_valid_o = done || (eop_i && (cnt_q != '0));
  assign cap_data_o  = done ? merged : sh_q;
  assign eop_bits_o  = {1'b0, cnt_q};
  assign bit_cnt_o   = cnt_q;
  assign len_m1_o    = len_eff;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sh_q  <= '0;
      len_q <= IDX_W'(DEF_BITS - 1);
    end else begin
      if (cnt_q == '0) len_q <= len_m1_i;
      if (eop_i || done) begin
        cnt_q <= '0;
        sh_q  <= '0;
      end else if (take) begin
        cnt_q <= cnt_q + 1'b1;
        sh_q  <= merged;
      end
    end
  end
endmodule

// File: rtl/sr_rx_regs.sv
module sr_rx_regs
  import sr_rx_pkg::*;
#(
  parameter int REG_W    = 16,
  parameter int BUF_W    = 16,
  parameter int PAT_W    = 8,
  parameter int DEF_BITS = 8,
  localparam int IDX_W = $clog2(BUF_W),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       addr_i,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             rd_i,
  output logic [REG_W-1:0] rdata_o,
  input  logic             cap_valid_i,
  input  logic [BUF_W-1:0] cap_data_i,
  input  logic             eop_i,
  input  logic [CNT_W-1:0] eop_bits_i,
  input  logic             hunt_i,
  output rx_ctrl_t         ctrl_o,
  output logic [PAT_W-1:0] pattern_o,
  output logic [IDX_W-1:0] len_m1_o,
  output logic             irq_o
);
  rx_ctrl_t         ctrl_q;
  logic [PAT_W-1:0] pat_q;
  logic [IDX_W-1:0] len_q;
  logic [BUF_W-1:0] buf_q;
  logic [CNT_W-1:0] rcnt_q;
  logic             full_q, eopf_q, ovr_q;
  logic             wr_flags, full_clr;
  logic [2:0]       w1c;

  assign wr_flags = wr_i && (addr_i == RA_FLAGS);
  assign w1c      = wr_flags ? wdata_i[2:0] : 3'b000;
  assign full_clr = w1c[FL_FULL] || (rd_i && (addr_i == RA_BUF));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      pat_q  <= '0;
      len_q  <= IDX_W'(DEF_BITS - 1);
      buf_q  <= '0;
      rcnt_q <= '0;
      full_q <= 1'b0;
      eopf_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (wr_i && (addr_i == RA_CTRL)) ctrl_q <= rx_ctrl_t'(wdata_i[3:0]);
      if (wr_i && (addr_i == RA_SYNC)) pat_q  <= wdata_i[PAT_W-1:0];
      if (wr_i && (addr_i == RA_LEN))  len_q  <= wdata_i[IDX_W-1:0];
      if (cap_valid_i) buf_q <= cap_data_i;
      if (eop_i) rcnt_q <= eop_bits_i;

      if (cap_valid_i)   full_q <= 1'b1;
      else if (full_clr) full_q <= 1'b0;

      if (eop_i)            eopf_q <= 1'b1;
      else if (w1c[FL_EOP]) eopf_q <= 1'b0;

      if (cap_valid_i && full_q && !full_clr) ovr_q <= 1'b1;
      else if (w1c[FL_OVR])                   ovr_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      RA_CTRL:  rdata_o = REG_W'(ctrl_q);
      RA_SYNC:  rdata_o = REG_W'(pat_q);
      RA_LEN:   rdata_o = REG_W'(len_q);
      RA_BUF:   rdata_o = REG_W'(buf_q);
      RA_RCNT:  rdata_o = REG_W'(rcnt_q);
      RA_FLAGS: rdata_o = REG_W'({hunt_i, ovr_q, eopf_q, full_q});
      default:  rdata_o = '0;
    endcase
  end

  assign ctrl_o    = ctrl_q;
  assign pattern_o = pat_q;
  assign len_m1_o  = len_q;
  assign irq_o     = (full_q && ctrl_q.ie_full) || (eopf_q && ctrl_q.ie_eop);
endmodule

// File: rtl/sr_deser_rx.sv
module sr_deser_rx
  import sr_rx_pkg::*;
#(
  parameter int REG_W    = 16,
  parameter int BUF_W    = 16,
  parameter int PAT_W    = 8,
  parameter int DEF_BITS = 8,
  localparam int IDX_W = $clog2(BUF_W),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_i,
  input  logic             bit_stb_i,
  input  logic             eop_i,
  input  logic [2:0]       reg_addr_i,
  input  logic             reg_wr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  input  logic             reg_rd_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic             irq_o
);
  rx_ctrl_t         ctrl;
  logic [PAT_W-1:0] pattern;
  logic [IDX_W-1:0] len_m1, len_active, bit_cnt;
  logic [BUF_W-1:0] cap_data;
  logic [CNT_W-1:0] eop_bits;
  logic             bit_v, match, hunting_q, searching, run, cap_valid;

  assign bit_v     = bit_i ^ ctrl.invert;
  assign searching = hunting_q && !ctrl.bypass;
  assign run       = !hunting_q || ctrl.bypass;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    hunting_q <= 1'b1;
    else if (eop_i) hunting_q <= 1'b1;
    else if (match) hunting_q <= 1'b0;
  end

  sr_rx_sync #(.PAT_W(PAT_W)) sync_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bit_stb_i (bit_stb_i),
    .bit_val_i (bit_v),
    .arm_i     (eop_i),
    .enable_i  (searching),
    .pattern_i (pattern),
    .match_o   (match)
  );

  sr_rx_shift #(.BUF_W(BUF_W), .DEF_BITS(DEF_BITS)) shift_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bit_stb_i   (bit_stb_i),
    .bit_val_i   (bit_v),
    .eop_i       (eop_i),
    .run_i       (run),
    .len_m1_i    (len_m1),
    .cap_valid_o (cap_valid),
    .cap_data_o  (cap_data),
    .eop_bits_o  (eop_bits),
    .bit_cnt_o   (bit_cnt),
    .len_m1_o    (len_active)
  );

  sr_rx_regs #(
    .REG_W(REG_W), .BUF_W(BUF_W), .PAT_W(PAT_W), .DEF_BITS(DEF_BITS)
  ) regs_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .addr_i      (reg_addr_i),
    .wr_i        (reg_wr_i),
    .wdata_i     (reg_wdata_i),
    .rd_i        (reg_rd_i),
    .rdata_o     (reg_rdata_o),
    .cap_valid_i (cap_valid),
    .cap_data_i  (cap_data),
    .eop_i       (eop_i),
    .eop_bits_i  (eop_bits),
    .hunt_i      (searching),
    .ctrl_o      (ctrl),
    .pattern_o   (pattern),
    .len_m1_o    (len_m1),
    .irq_o       (irq_o)
  );
endmodule

// File: rtl/sr_deser_rx_chk.sv
module sr_deser_rx_chk #(
  parameter int IDX_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             bit_stb_i,
  input logic             eop_i,
  input logic [2:0]       reg_addr_i,
  input logic             reg_rd_i,
  input logic             irq_o,
  input logic             hunting,
  input logic             bypass,
  input logic             ie_full,
  input logic             ie_eop,
  input logic             full,
  input logic             ovr,
  input logic [IDX_W-1:0] bit_cnt,
  input logic [IDX_W-1:0] len_active
);
  assert_hunt_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hunting && !bypass) |-> (bit_cnt == '0));

  assert_cnt_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_cnt != '0) |-> (bit_cnt <= len_active));

  assert_eop_rearm_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eop_i |=> (hunting && (bit_cnt == '0)));

  assert_full_source_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(full) |-> $past(bit_stb_i || eop_i));

  assert_read_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_i && (reg_addr_i == 3'd3) && !bit_stb_i && !eop_i) |=> !full);

  assert_ovr_source_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr) |-> $past(full));

  assert_irq_masked_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ie_full && !ie_eop) |-> !irq_o);
endmodule

bind sr_deser_rx sr_deser_rx_chk #(.IDX_W(IDX_W)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bit_stb_i  (bit_stb_i),
  .eop_i      (eop_i),
  .reg_addr_i (reg_addr_i),
  .reg_rd_i   (reg_rd_i),
  .irq_o      (irq_o),
  .hunting    (hunting_q),
  .bypass     (ctrl.bypass),
  .ie_full    (ctrl.ie_full),
  .ie_eop     (ctrl.ie_eop),
  .full       (regs_i.full_q),
  .ovr        (regs_i.ovr_q),
  .bit_cnt    (bit_cnt),
  .len_active (len_active)
);

// File: tb/sr_deser_rx_tb_top.sv
module sr_deser_rx_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bit_i = 1'b0;
  logic        bit_stb_i = 1'b0;
  logic        eop_i = 1'b0;
  logic [2:0]  reg_addr_i = 3'd0;
  logic        reg_wr_i = 1'b0;
  logic [15:0] reg_wdata_i = 16'd0;
  logic        reg_rd_i = 1'b0;
  logic [15:0] reg_rdata_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;

  always #4 clk_i = ~clk_i;

  sr_deser_rx dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .bit_i(bit_i), .bit_stb_i(bit_stb_i),
    .eop_i(eop_i), .reg_addr_i(reg_addr_i), .reg_wr_i(reg_wr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rd_i(reg_rd_i), .reg_rdata_o(reg_rdata_o),
    .irq_o(irq_o)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk_i);
    reg_addr_i = a; reg_wdata_i = d; reg_wr_i = 1'b1;
    @(negedge clk_i);
    reg_wr_i = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk_i);
    reg_addr_i = a; reg_rd_i = 1'b1;
    #1 d = reg_rdata_o;
    @(negedge clk_i);
    reg_rd_i = 1'b0;
  endtask

  task automatic expect_reg(input string req, input logic [2:0] a, input logic [15:0] exp);
    logic [15:0] v;
    rd_reg(a, v);
    check(req, $sformatf("reg%0d", a), {16'd0, v}, {16'd0, exp});
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk_i);
    bit_i = b; bit_stb_i = 1'b1;
    @(negedge clk_i);
    bit_stb_i = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) send_bit(v[i]);
  endtask

  task automatic pulse_eop(input logic with_bit);
    @(negedge clk_i);
    eop_i = 1'b1; bit_stb_i = with_bit; bit_i = 1'b1;
    @(negedge clk_i);
    eop_i = 1'b0; bit_stb_i = 1'b0;
  endtask

  function automatic logic [15:0] place(input logic [15:0] acc, input logic b, input int idx);
    return acc | (16'(b) << idx);
  endfunction

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    expect_reg("R1", 3'd0, 16'h0);
    expect_reg("R1", 3'd1, 16'h0);
    expect_reg("R1", 3'd2, 16'h7);
    expect_reg("R1", 3'd3, 16'h0);
    expect_reg("R1", 3'd4, 16'h0);
    expect_reg("R1", 3'd5, 16'h8);
    check("R1", "irq", {31'd0, irq_o}, 32'd0);

    // R11 register readback
    wr_reg(3'd1, 16'h00D5);
    expect_reg("R11", 3'd1, 16'h00D5);
    wr_reg(3'd0, 16'h000A);
    expect_reg("R11", 3'd0, 16'h000A);
    wr_reg(3'd0, 16'h0000);

    // R3 match then word
    send_byte(8'hD5);
    expect_reg("R3", 3'd5, 16'h0);
    send_byte(8'h3C);
    expect_reg("R5", 3'd5, 16'h1);
    expect_reg("R5", 3'd3, 16'h003C);
    expect_reg("R7", 3'd5, 16'h0);

    // R4 pattern inside payload is data
    send_byte(8'hD5);
    expect_reg("R4", 3'd5, 16'h1);
    expect_reg("R4", 3'd3, 16'h00D5);

    // R8 overrun
    send_byte(8'h11);
    send_byte(8'h22);
    expect_reg("R8", 3'd5, 16'h5);
    expect_reg("R8", 3'd3, 16'h0022);
    expect_reg("R7", 3'd5, 16'h4);
    wr_reg(3'd5, 16'h0004);
    expect_reg("R8", 3'd5, 16'h0);

    // R9 interrupt gating
    wr_reg(3'd0, 16'h0002);
    send_byte(8'h01);
    check("R9", "irq full enabled", {31'd0, irq_o}, 32'd1);
    expect_reg("R9", 3'd3, 16'h0001);
    check("R9", "irq after read", {31'd0, irq_o}, 32'd0);
    wr_reg(3'd0, 16'h0000);
    send_byte(8'h02);
    check("R9", "irq masked", {31'd0, irq_o}, 32'd0);
    wr_reg(3'd5, 16'h0001);
    expect_reg("R7", 3'd5, 16'h0);

    // R6 end of packet with partial word
    wr_reg(3'd0, 16'h0004);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    pulse_eop(1'b0);
    expect_reg("R6", 3'd5, 16'hB);
    check("R9", "irq eop", {31'd0, irq_o}, 32'd1);
    expect_reg("R6", 3'd4, 16'h3);
    expect_reg("R6", 3'd3, 16'h0005);
    wr_reg(3'd5, 16'h0003);
    check("R9", "irq cleared", {31'd0, irq_o}, 32'd0);
    wr_reg(3'd0, 16'h0000);

    // R6 strobe coinciding with eop is dropped
    send_byte(8'hD5);
    send_bit(1'b1); send_bit(1'b1);
    pulse_eop(1'b1);
    expect_reg("R6", 3'd4, 16'h2);
    expect_reg("R6", 3'd3, 16'h0003);
    wr_reg(3'd5, 16'h0007);

    // R5 length latched at first bit of a word
    send_byte(8'hD5);
    send_bit(1'b1); send_bit(1'b0);
    wr_reg(3'd2, 16'h0003);
    send_bit(1'b1); send_bit(1'b1);
    expect_reg("R5", 3'd5, 16'h0);
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
    expect_reg("R5", 3'd3, 16'h00FD);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b0); send_bit(1'b1);
    expect_reg("R5", 3'd3, 16'h0009);
    pulse_eop(1'b0);
    wr_reg(3'd5, 16'h0007);
    wr_reg(3'd2, 16'h0007);

    // R3 fewer than eight bits never match
    wr_reg(3'd1, 16'h0000);
    send_bit(1'b0); send_bit(1'b0); send_bit(1'b0);
    expect_reg("R3", 3'd5, 16'h8);
    wr_reg(3'd1, 16'h00D5);

    // R2 inversion
    wr_reg(3'd0, 16'h0001);
    send_byte(8'hD5);
    expect_reg("R2", 3'd5, 16'h8);
    send_byte(~8'hD5);
    expect_reg("R2", 3'd5, 16'h0);
    send_byte(~8'h5A);
    expect_reg("R2", 3'd3, 16'h005A);
    pulse_eop(1'b0);
    wr_reg(3'd5, 16'h0007);

    // R10 bypass
    wr_reg(3'd0, 16'h0008);
    wr_reg(3'd2, 16'h0003);
    expect_reg("R10", 3'd5, 16'h0);
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
    expect_reg("R10", 3'd5, 16'h1);
    expect_reg("R10", 3'd3, 16'h0006);
    wr_reg(3'd0, 16'h0000);
    pulse_eop(1'b0);
    wr_reg(3'd5, 16'h0007);

    // Random frames: R2 R3 R5 R6
    for (int f = 0; f < 24; f++) begin
      int n;
      int len;
      int idx;
      logic inv;
      logic [7:0] pat;
      logic [15:0] exp;
      n   = int'($urandom_range(1, 16));
      len = int'($urandom_range(0, 40));
      inv = 1'($urandom());
      pat = 8'($urandom());
      wr_reg(3'd0, {15'd0, inv});
      wr_reg(3'd1, {8'd0, pat});
      wr_reg(3'd2, 16'(n - 1));
      pulse_eop(1'b0);
      wr_reg(3'd5, 16'h0007);
      for (int i = 0; i < 8; i++) send_bit(pat[i] ^ inv);
      idx = 0; exp = 16'd0;
      for (int i = 0; i < len; i++) begin
        logic b;
        b = 1'($urandom());
        send_bit(b ^ inv);
        exp = place(exp, b, idx);
        idx++;
        if (idx == n) begin
          expect_reg("R5", 3'd3, exp);
          idx = 0; exp = 16'd0;
        end
      end
      pulse_eop(1'b0);
      expect_reg("R6", 3'd4, 16'(idx));
      if (idx > 0) expect_reg("R6", 3'd3, exp);
      wr_reg(3'd5, 16'h0007);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule